// File: doc/BRIEF.md
# Sigma-Delta Converter Readout Controller

This block sits on the host side of a pin-configured 24-bit sigma-delta converter that has a serial output. It drives the converter's two rate-select pins and two gain-select pins from a configuration input. It holds the converter's combined chip-select/power-down line low while the converter is in use. The converter reports a finished conversion by pulling its serial data line low, because that line also carries the ready indication. When the controller sees this, it clocks out one 24-bit result in SPI mode 3 and presents the result on a parallel bus with a one-cycle strobe.

The serial clock is divided down from the system clock by a programmable half-period. A programmable watchdog flags a converter that never reports ready. An overrun flag shows that a result was overwritten before the consumer acknowledged it. Any change of rate or gain updates the pins at once and discards the next result, because that conversion may still be settling. A power-down request lets a transfer in progress finish, then raises the chip-select line. The line stays high until an enable request arrives.

Top module: `sdadc_reader`

## Requirements
- R1: After reset, `adc_cs_n` and `adc_sclk` are high, `sample_valid`, `overrun` and `timeout` are low, and both pin pairs are 00. The controller stays powered down and issues no serial clock, whatever `adc_dout` does, until `en_req` is pulsed.
- R2: An `en_req` pulse while powered down drives `adc_cs_n` low in the following cycle. Ready is the data line, passed through a two-stage synchronizer, being seen high and then low while `adc_cs_n` is low.
- R3: After ready, exactly 24 serial clock periods are issued, each a falling edge followed by a rising edge. Each half-period lasts `max(sclk_div, 4)` system cycles, and `adc_sclk` rests high whenever no transfer runs. No falling edge comes before ready.
- R4: Data bits are taken at each rising serial edge, first bit most significant. The unsigned 24-bit word appears on `sample_data`, with `sample_valid` high for exactly one cycle, in the cycle in which `adc_sclk` returns high after the 24th period.
- R5: `rate_pins` follows `cfg_rate` and `gain_pins` follows `cfg_gain`, one cycle after a change. The rate code is 00=120 Hz, 01=60 Hz, 10=50 Hz, 11=10 Hz. The gain code is 00=x1, 01=x8, 10=x64, 11=x128.
- R6: After a change of either configuration input, the next ready still gets 24 serial periods, but no `sample_valid` is raised for it. The ready after that is delivered normally.
- R7: `overrun` goes high when a result is delivered while the previous result is still unacknowledged. An `ack` pulse clears both the pending state and `overrun`.
- R8: `timeout` rises once the controller has waited `wd_limit` cycles for ready without seeing it. It falls when ready arrives or the converter is powered down. A `wd_limit` of 0 disables it.
- R9: A `pd_req` pulse during a transfer lets all 24 periods finish and the result be delivered. `adc_cs_n` is raised in the same cycle that `adc_sclk` returns high, and never while `adc_sclk` is low.
- R10: A `pd_req` pulse while waiting for ready raises `adc_cs_n` in the next cycle. After a new `en_req`, a data line that is already low does not start a transfer. The line must first be seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rate | input | 2 | Requested rate-select code |
| cfg_gain | input | 2 | Requested gain-select code |
| pd_req | input | 1 | Power-down request pulse |
| en_req | input | 1 | Power-up request pulse |
| ack | input | 1 | Consumer acknowledges the held result |
| sclk_div | input | DIV_W | Serial clock half-period in system cycles (minimum 4 applied) |
| wd_limit | input | WD_W | Ready watchdog limit in cycles, 0 disables |
| adc_dout | input | 1 | Converter serial data / ready line |
| adc_cs_n | output | 1 | Chip-select, high powers the converter down |
| adc_sclk | output | 1 | Serial clock, idles high |
| rate_pins | output | 2 | Rate-select pin pair |
| gain_pins | output | 2 | Gain-select pin pair |
| sample_data | output | 24 | Last delivered result |
| sample_valid | output | 1 | One-cycle strobe for a new result |
| overrun | output | 1 | A result was delivered over an unacknowledged one |
| timeout | output | 1 | Ready has not arrived within the watchdog limit |

## Verification
The transfer is driven with words that are alternating in nibbles, all zeros, all ones, and with only the top and bottom bits set. These patterns distinguish a reversed bit order, a dropped or duplicated bit, and a stuck data path. The all-zero word also shows whether a trailing low data bit is mistaken for the next ready. Two half-period settings, one below the minimum, show the clamp at work, and counting the low serial-clock cycles per transfer confirms both the period and the count of 24. Power-down is requested both while the controller waits and in the middle of a transfer. This separates an immediate release of chip-select from a deferred one. Holding the data line low across re-enable separates level detection of ready from the required high-then-low detection.

// File: rtl/sdadc_pkg.sv
`timescale 1ns/1ps
package sdadc_pkg;
    localparam int SAMPLE_W = 24;
    localparam int BIT_W    = $clog2(SAMPLE_W);

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e          st;
        logic                cs_n;
        logic                sclk;
        logic [BIT_W-1:0]    bits;
        logic [SAMPLE_W-1:0] sr;
        logic                armed;
        logic                disc_pend;
        logic                xfer_disc;
        logic                pd_pend;
        logic [SAMPLE_W-1:0] data;
        logic                valid;
        logic                held;
        logic                ovr;
        logic [1:0]          rate;
        logic [1:0]          gain;
    } ctl_regs_t;
endpackage

// File: rtl/sdadc_sync.sv
`timescale 1ns/1ps
module sdadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/sdadc_clkdiv.sv
`timescale 1ns/1ps
module sdadc_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == half - 1'b1);
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sdadc_watchdog.sv
`timescale 1ns/1ps
module sdadc_watchdog #(
    parameter int WD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [WD_W-1:0] limit,
    output logic            expired
);
    logic [WD_W-1:0] cnt_d, cnt_q;
    logic            exp_d, exp_q;

    always_comb begin
        cnt_d = cnt_q;
        exp_d = exp_q;
        if (!run) begin
            cnt_d = '0;
            exp_d = 1'b0;
        end else if (limit != '0 && !exp_q) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_d == limit) exp_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            exp_q <= exp_d;
        end
    end

    assign expired = exp_q && run;
endmodule

// File: rtl/sdadc_reader.sv
`timescale 1ns/1ps
module sdadc_reader
    import sdadc_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int WD_W        = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HALF    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_rate,
    input  logic [1:0]          cfg_gain,
    input  logic                pd_req,
    input  logic                en_req,
    input  logic                ack,
    input  logic [DIV_W-1:0]    sclk_div,
    input  logic [WD_W-1:0]     wd_limit,
    input  logic                adc_dout,
    output logic                adc_cs_n,
    output logic                adc_sclk,
    output logic [1:0]          rate_pins,
    output logic [1:0]          gain_pins,
    output logic [SAMPLE_W-1:0] sample_data,
    output logic                sample_valid,
    output logic                overrun,
    output logic                timeout
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SAMPLE_W - 1);
    localparam logic [DIV_W-1:0] HALF_MIN = DIV_W'(MIN_HALF);

    localparam ctl_regs_t REGS_RST = '{
        st: ST_OFF, cs_n: 1'b1, sclk: 1'b1, bits: '0, sr: '0,
        armed: 1'b0, disc_pend: 1'b0, xfer_disc: 1'b0, pd_pend: 1'b0,
        data: '0, valid: 1'b0, held: 1'b0, ovr: 1'b0,
        rate: 2'b00, gain: 2'b00
    };

    ctl_regs_t        r_d, r_q;
    logic             dout_s;
    logic             half_tick;
    logic [DIV_W-1:0] half_cycles;
    logic [SAMPLE_W-1:0] sr_next;

    assign half_cycles = (sclk_div < HALF_MIN) ? HALF_MIN : sclk_div;

    sdadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (adc_dout),
        .dout (dout_s)
    );

    sdadc_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (r_q.st == ST_SHIFT),
        .half (half_cycles),
        .tick (half_tick)
    );

    sdadc_watchdog #(.WD_W(WD_W)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (r_q.st == ST_WAIT),
        .limit  (wd_limit),
        .expired(timeout)
    );

    assign sr_next = {r_q.sr[SAMPLE_W-2:0], dout_s};

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;

        if (ack) begin
            r_d.held = 1'b0;
            r_d.ovr  = 1'b0;
        end
        if (pd_req) r_d.pd_pend = 1'b1;

        case (r_q.st)
            ST_OFF: begin
                r_d.pd_pend = 1'b0;
                if (en_req && !pd_req) begin
                    r_d.st    = ST_WAIT;
                    r_d.cs_n  = 1'b0;
                    r_d.armed = 1'b0;
                end
            end
            ST_WAIT: begin
                if (pd_req || r_q.pd_pend) begin
                    r_d.st      = ST_OFF;
                    r_d.cs_n    = 1'b1;
                    r_d.pd_pend = 1'b0;
                end else if (r_q.armed && !dout_s) begin
                    r_d.st        = ST_SHIFT;
                    r_d.armed     = 1'b0;
                    r_d.bits      = '0;
                    r_d.xfer_disc = r_q.disc_pend;
                    r_d.disc_pend = 1'b0;
                end else if (dout_s) begin
                    r_d.armed = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (half_tick) begin
                    if (r_q.sclk) begin
                        r_d.sclk = 1'b0;
                    end else begin
                        r_d.sclk = 1'b1;
                        r_d.sr   = sr_next;
                        r_d.bits = r_q.bits + 1'b1;
                        if (r_q.bits == LAST_BIT) begin
                            if (!r_q.xfer_disc) begin
                                r_d.data  = sr_next;
                                r_d.valid = 1'b1;
                                if (r_q.held && !ack) r_d.ovr = 1'b1;
                                r_d.held = 1'b1;
                            end
                            r_d.xfer_disc = 1'b0;
                            if (r_d.pd_pend) begin
                                r_d.st      = ST_OFF;
                                r_d.cs_n    = 1'b1;
                                r_d.pd_pend = 1'b0;
                            end else begin
                                r_d.st = ST_WAIT;
                            end
                        end
                    end
                end
            end
            default: r_d = REGS_RST;
        endcase

        if (cfg_rate != r_q.rate || cfg_gain != r_q.gain) begin
            r_d.rate      = cfg_rate;
            r_d.gain      = cfg_gain;
            r_d.disc_pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign adc_cs_n     = r_q.cs_n;
    assign adc_sclk     = r_q.sclk;
    assign rate_pins    = r_q.rate;
    assign gain_pins    = r_q.gain;
    assign sample_data  = r_q.data;
    assign sample_valid = r_q.valid;
    assign overrun      = r_q.ovr;
endmodule

// File: rtl/sdadc_reader_chk.sv
`timescale 1ns/1ps
module sdadc_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic sample_valid,
    input logic overrun,
    input logic timeout
);
    // R3: serial clock rests high whenever the converter is powered down
    assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> adc_sclk);

    // R9: chip-select never high while the serial clock is low
    assert_cs_low_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_sclk |-> !adc_cs_n);

    // R4: result strobe lasts one cycle
    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R7: overrun only rises together with a delivered result
    assert_ovr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> sample_valid);

    // R8: timeout only reported while the converter is active
    assert_timeout_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !adc_cs_n);
endmodule

bind sdadc_reader sdadc_reader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_cs_n    (adc_cs_n),
    .adc_sclk    (adc_sclk),
    .sample_valid(sample_valid),
    .overrun     (overrun),
    .timeout     (timeout)
);

// File: tb/sdadc_reader_test.sv
`timescale 1ns/1ps
module sdadc_reader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_rate = 2'b00, cfg_gain = 2'b00;
    logic        pd_req = 1'b0, en_req = 1'b0, ack = 1'b0;
    logic [7:0]  sclk_div = 8'd6;
    logic [15:0] wd_limit = 16'd0;
    logic        adc_dout = 1'b1;
    logic        adc_cs_n, adc_sclk, sample_valid, overrun, timeout;
    logic [1:0]  rate_pins, gain_pins;
    logic [23:0] sample_data;

    int n_chk = 0, n_fail = 0;
    int vcount = 0, falls = 0, lowcyc = 0, early = 0;
    logic [23:0] last_data = '0;
    bit rdy = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdadc_reader uut (
        .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_gain(cfg_gain),
        .pd_req(pd_req), .en_req(en_req), .ack(ack), .sclk_div(sclk_div),
        .wd_limit(wd_limit), .adc_dout(adc_dout), .adc_cs_n(adc_cs_n),
        .adc_sclk(adc_sclk), .rate_pins(rate_pins), .gain_pins(gain_pins),
        .sample_data(sample_data), .sample_valid(sample_valid),
        .overrun(overrun), .timeout(timeout)
    );

    always @(negedge clk) begin
        if (sample_valid) begin
            vcount++;
            last_data = sample_data;
        end
        if (!adc_cs_n && !adc_sclk) lowcyc++;
    end

    always @(negedge adc_sclk) begin
        falls++;
        if (!rdy) early++;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_en();
        @(negedge clk) en_req = 1'b1;
        @(negedge clk) en_req = 1'b0;
    endtask

    task automatic pulse_pd();
        @(negedge clk) pd_req = 1'b1;
        @(negedge clk) pd_req = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
    endtask

    // converter model: ready low, then one bit per falling serial edge
    task automatic do_convert(input logic [23:0] val);
        adc_dout = 1'b1;
        idle(6);
        rdy = 1'b1;
        adc_dout = 1'b0;
        for (int i = 23; i >= 0; i--) begin
            @(negedge adc_sclk);
            #1 adc_dout = val[i];
            @(posedge adc_sclk);
        end
        #1 adc_dout = 1'b1;
        rdy = 1'b0;
        idle(3);
    endtask

    task automatic xfer_check(input string req, input logic [23:0] val,
                              input int half, input bit deliver);
        int v0, f0, l0;
        v0 = vcount; f0 = falls; l0 = lowcyc;
        do_convert(val);
        chk(req, "falling edges", 32'(falls - f0), 32'd24);
        chk(req, "low sclk cycles", 32'(lowcyc - l0), 32'(24 * half));
        chk(req, "strobes", 32'(vcount - v0), deliver ? 32'd1 : 32'd0);
        if (deliver) chk(req, "data", {8'h0, last_data}, {8'h0, val});
    endtask

    task automatic t_reset();
        chk("R1", "cs_n", {31'h0, adc_cs_n}, 32'd1);
        chk("R1", "sclk", {31'h0, adc_sclk}, 32'd1);
        chk("R1", "valid/ovr/timeout", {29'h0, sample_valid, overrun, timeout}, 32'd0);
        chk("R1", "pins", {28'h0, rate_pins, gain_pins}, 32'd0);
        adc_dout = 1'b0; idle(20); adc_dout = 1'b1; idle(10);
        chk("R1", "no clock while down", 32'(falls), 32'd0);
        chk("R1", "still down", {31'h0, adc_cs_n}, 32'd1);
    endtask

    task automatic t_basic();
        pulse_en();
        chk("R2", "cs_n after enable", {31'h0, adc_cs_n}, 32'd0);
        xfer_check("R4", 24'hA5C3F1, 6, 1'b1);
        chk("R3", "no early edge", 32'(early), 32'd0);
        chk("R3", "sclk idle high", {31'h0, adc_sclk}, 32'd1);
        pulse_ack();
    endtask

    task automatic t_patterns();
        xfer_check("R4", 24'h000000, 6, 1'b1); pulse_ack();
        xfer_check("R4", 24'hFFFFFF, 6, 1'b1); pulse_ack();
        xfer_check("R4", 24'h800001, 6, 1'b1); pulse_ack();
    endtask

    task automatic t_clamp();
        sclk_div = 8'd1;
        xfer_check("R3", 24'h5A5A5A, 4, 1'b1); pulse_ack();
        sclk_div = 8'd6;
    endtask

    task automatic t_cfg();
        @(negedge clk) begin cfg_rate = 2'b10; cfg_gain = 2'b11; end
        idle(1);
        chk("R5", "rate pins", {30'h0, rate_pins}, 32'd2);
        chk("R5", "gain pins", {30'h0, gain_pins}, 32'd3);
        xfer_check("R6", 24'h123456, 6, 1'b0);
        xfer_check("R6", 24'h654321, 6, 1'b1); pulse_ack();
    endtask

    task automatic t_overrun();
        xfer_check("R7", 24'h0F0F0F, 6, 1'b1);
        chk("R7", "no overrun yet", {31'h0, overrun}, 32'd0);
        xfer_check("R7", 24'hF0F0F0, 6, 1'b1);
        chk("R7", "overrun set", {31'h0, overrun}, 32'd1);
        pulse_ack();
        chk("R7", "overrun cleared", {31'h0, overrun}, 32'd0);
    endtask

    task automatic t_timeout();
        pulse_pd();
        wd_limit = 16'd40;
        pulse_en();
        idle(20);
        chk("R8", "timeout early", {31'h0, timeout}, 32'd0);
        idle(40);
        chk("R8", "timeout set", {31'h0, timeout}, 32'd1);
        xfer_check("R8", 24'h777777, 6, 1'b1); pulse_ack();
        pulse_pd();
        chk("R8", "cleared by power-down", {31'h0, timeout}, 32'd0);
        wd_limit = 16'd0;
        pulse_en();
        idle(100);
        chk("R8", "disabled", {31'h0, timeout}, 32'd0);
    endtask

    task automatic t_pd_mid();
        int v0, f0;
        v0 = vcount; f0 = falls;
        fork
            do_convert(24'h3C96E1);
            begin
                repeat (10) @(negedge adc_sclk);
                pulse_pd();
            end
        join
        chk("R9", "edges", 32'(falls - f0), 32'd24);
        chk("R9", "strobes", 32'(vcount - v0), 32'd1);
        chk("R9", "data", {8'h0, last_data}, 32'h003C96E1);
        chk("R9", "cs_n raised", {31'h0, adc_cs_n}, 32'd1);
        chk("R9", "sclk high", {31'h0, adc_sclk}, 32'd1);
        pulse_ack();
    endtask

    task automatic t_pd_wait();
        int f0;
        pulse_en();
        idle(10);
        @(negedge clk) pd_req = 1'b1;
        @(negedge clk) pd_req = 1'b0;
        chk("R10", "cs_n next cycle", {31'h0, adc_cs_n}, 32'd1);
        adc_dout = 1'b0;
        idle(5);
        f0 = falls;
        pulse_en();
        idle(40);
        chk("R10", "no start on held low", 32'(falls - f0), 32'd0);
        chk("R10", "active", {31'h0, adc_cs_n}, 32'd0);
        xfer_check("R10", 24'hC0FFEE, 6, 1'b1); pulse_ack();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_basic();
        t_patterns();
        t_clamp();
        t_cfg();
        t_overrun();
        t_timeout();
        t_pd_mid();
        t_pd_wait();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule